// File: doc/BRIEF.md
# Interrupt Active Priority Tracker

This block keeps, for one processor's interrupt interface, the record of which priority levels are currently being serviced. Each interrupt group owns a vector with one bit per preemption level. When an interrupt is taken, an activate strobe marks its level in its group's vector. When its handler finishes, a drop strobe retires the most urgent level still marked. From the stored vectors the block derives, combinationally, the running priority of the processor and the group that owns it.

The block also holds one binary point value per group and turns each into the group priority mask used when deciding whether a pending interrupt may preempt. A common binary point switch makes every group other than group 0 follow group 0's value plus one. Group 0's value is used directly. Commands are single-cycle strobes and take effect on the next clock edge. The status outputs are decoded from registered state and need no handshake.

Top module: `apt_tracker`

## Requirements
- R1: After reset no level is active in any group: `running_prio` is 0xFF, `any_active` is 0, `owner_group` is 0, and every stored binary point equals the minimum MIN_BP = 7 - PRIO_BITS (0 when PRIO_BITS is 7 or more). With the default PRIO_BITS = 6, each group mask reads 0xFC.
- R2: An activate strobe with a valid group marks level index `act_prio >> (8 - PRIO_BITS)` in that group on the next clock edge. The low priority bits below the level granularity are ignored.
- R3: `running_prio` equals the lowest marked level index over all groups, shifted left by (8 - PRIO_BITS). It is 0xFF when no level is marked anywhere.
- R4: `owner_group` names the group holding the lowest marked index. When several groups hold the same lowest index, the lowest-numbered group wins.
- R5: A drop strobe whose `drop_group` equals the current `owner_group` clears exactly the lowest marked bit of that group on the next edge. A drop naming any other group, or a drop when nothing is active, changes nothing.
- R6: When activate and drop arrive in the same cycle, the drop is judged on the state before the edge, and the activation is applied after the clear. Activating a level that is already marked leaves a single mark, which one drop removes.
- R7: An activate strobe whose group number is NUM_GROUPS or higher is ignored.
- R8: A binary point write (`bp_val`, 0..7) below MIN_BP stores MIN_BP. Each group mask equals 0xFF shifted left by (binary point + 1), so a binary point of 7 gives 0x00. Group g's mask occupies `prio_mask[8g+7:8g]`.
- R9: While `common_bp` is 1, every group other than group 0 uses min(group 0 binary point + 1, 7) for its mask. Its own stored value is kept and returns when `common_bp` drops to 0. Group 0 always uses its own value.
- R10: The levels of each group are stored as 32-bit words (word = index / 32, bit = index % 32). Ordering, drop and ownership behave identically across a word boundary, for example index 31 versus index 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_valid | input | 1 | Activate strobe |
| act_prio | input | 8 | Priority of the activated interrupt |
| act_group | input | GW | Group of the activated interrupt |
| drop_valid | input | 1 | Priority drop strobe |
| drop_group | input | GW | Group the drop is issued for |
| bp_wr | input | 1 | Binary point write strobe |
| bp_group | input | GW | Group whose binary point is written |
| bp_val | input | 3 | Requested binary point |
| common_bp | input | 1 | Groups above 0 follow group 0's binary point |
| running_prio | output | 8 | Highest active priority, 0xFF when idle |
| any_active | output | 1 | At least one level marked |
| owner_group | output | GW | Group owning the running priority |
| prio_mask | output | 8*NUM_GROUPS | Per-group priority masks |

## Verification
The assertions assume that `act_prio` and `act_group` are stable whenever `act_valid` is high at an edge, and that strobes are never X. They also assume that an activate never carries a priority numerically above 0xFF once masked, which holds for any 8-bit value. The bench drives every input a short delay after the rising edge and releases the strobes after one edge, so each command is seen exactly once. The bench only activates out-of-range groups in the test that checks R7. All expected values follow from the requirement formulas worked by hand.

// File: rtl/apt_pkg.sv
package apt_pkg;

    typedef logic [2:0] bp_t;

    // Mask of the bits that take part in group-priority comparison.
    function automatic logic [7:0] bp_to_mask(input bp_t bp);
        logic [3:0] sh;
        sh = 4'(bp) + 4'd1;
        return 8'hFF << sh;
    endfunction

    function automatic bp_t bp_follow(input bp_t bp0);
        return (bp0 == 3'd7) ? 3'd7 : bp0 + 3'd1;
    endfunction

endpackage

// File: rtl/apt_group_bank.sv
module apt_group_bank #(
    parameter int PRIO_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_en,
    input  logic [PRIO_BITS-1:0] set_idx,
    input  logic                 clr_en,
    output logic                 has_any,
    output logic [PRIO_BITS-1:0] low_idx
);
    localparam int LEVELS = 1 << PRIO_BITS;
    localparam int WORDS  = (LEVELS + 31) / 32;

    logic [WORDS-1:0][31:0] word_q;
    logic [WORDS-1:0][31:0] word_d;
    logic [LEVELS-1:0]      lv;

    assign lv = word_q;

    // lowest marked level = most urgent
    always_comb begin
        low_idx = '0;
        for (int i = LEVELS - 1; i >= 0; i--) begin
            if (lv[i]) low_idx = PRIO_BITS'(i);
        end
    end

    assign has_any = |lv;

    always_comb begin
        int cw, cb, sw, sb;
        word_d = word_q;
        cw = int'(low_idx) / 32;
        cb = int'(low_idx) % 32;
        sw = int'(set_idx) / 32;
        sb = int'(set_idx) % 32;
        if (clr_en && has_any) word_d[cw][cb] = 1'b0;
        if (set_en)            word_d[sw][sb] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    // R2: an activation leaves its level marked
    a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> lv[$past(set_idx)]);

    // R5: a lone drop removes exactly one mark
    a_r5_clear_one: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en && has_any) |=> ($countones(lv) + 1 == $past($countones(lv))));

endmodule

// File: rtl/apt_owner_select.sv
module apt_owner_select #(
    parameter int PRIO_BITS  = 6,
    parameter int NUM_GROUPS = 3,
    parameter int GW         = 2
) (
    input  logic [NUM_GROUPS-1:0]                has_any,
    input  logic [NUM_GROUPS-1:0][PRIO_BITS-1:0] low_idx,
    output logic                                 found,
    output logic [PRIO_BITS-1:0]                 best_idx,
    output logic [GW-1:0]                        best_group
);
    // scanned from the top group down with <=, so ties go to the lower group
    always_comb begin
        found      = 1'b0;
        best_idx   = '0;
        best_group = '0;
        for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
            if (has_any[g] && (!found || low_idx[g] <= best_idx)) begin
                found      = 1'b1;
                best_idx   = low_idx[g];
                best_group = GW'(g);
            end
        end
    end

endmodule

// File: rtl/apt_bp_unit.sv
module apt_bp_unit
    import apt_pkg::*;
#(
    parameter int NUM_GROUPS = 3,
    parameter int GW         = 2,
    parameter int MIN_BP     = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bp_wr,
    input  logic [GW-1:0]           bp_group,
    input  bp_t                     bp_val,
    input  logic                    common_bp,
    output logic [8*NUM_GROUPS-1:0] prio_mask
);
    localparam bp_t BP_FLOOR = bp_t'(MIN_BP);

    bp_t bp_q [NUM_GROUPS];
    bp_t wr_clamped;

    assign wr_clamped = (bp_val < BP_FLOOR) ? BP_FLOOR : bp_val;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        bp_t eff;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bp_q[g] <= BP_FLOOR;
            else if (bp_wr && bp_group == GW'(g))
                bp_q[g] <= wr_clamped;
        end

        if (g == 0) begin : g_base
            assign eff = bp_q[0];
        end else begin : g_follow
            assign eff = common_bp ? bp_follow(bp_q[0]) : bp_q[g];
        end

        assign prio_mask[8*g +: 8] = bp_to_mask(eff);

        // R8: the stored binary point never sits below the floor
        a_r8_bp_floor: assert property (@(posedge clk) disable iff (!rst_n)
            bp_q[g] >= BP_FLOOR);
    end

endmodule

// File: rtl/apt_tracker.sv
module apt_tracker
    import apt_pkg::*;
#(
    parameter int PRIO_BITS  = 6,
    parameter int NUM_GROUPS = 3,
    parameter int GW         = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    act_valid,
    input  logic [7:0]              act_prio,
    input  logic [GW-1:0]           act_group,
    input  logic                    drop_valid,
    input  logic [GW-1:0]           drop_group,
    input  logic                    bp_wr,
    input  logic [GW-1:0]           bp_group,
    input  logic [2:0]              bp_val,
    input  logic                    common_bp,
    output logic [7:0]              running_prio,
    output logic                    any_active,
    output logic [GW-1:0]           owner_group,
    output logic [8*NUM_GROUPS-1:0] prio_mask
);
    localparam int SHIFT = 8 - PRIO_BITS;
    localparam int MIN_BP = (PRIO_BITS >= 7) ? 0 : 7 - PRIO_BITS;
    localparam logic [7:0] LEVEL_MASK = 8'hFF << SHIFT;

    logic [NUM_GROUPS-1:0]                has_any;
    logic [NUM_GROUPS-1:0][PRIO_BITS-1:0] low_idx;
    logic                                 found;
    logic [PRIO_BITS-1:0]                 best_idx;
    logic [GW-1:0]                        best_group;
    logic [PRIO_BITS-1:0]                 act_idx;
    logic                                 act_ok;
    logic                                 drop_ok;

    assign act_idx = act_prio[7:SHIFT];
    assign act_ok  = act_valid && (int'(act_group) < NUM_GROUPS);
    assign drop_ok = drop_valid && found && (drop_group == best_group);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bank
        apt_group_bank #(.PRIO_BITS(PRIO_BITS)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_en  (act_ok && act_group == GW'(g)),
            .set_idx (act_idx),
            .clr_en  (drop_ok && best_group == GW'(g)),
            .has_any (has_any[g]),
            .low_idx (low_idx[g])
        );
    end

    apt_owner_select #(
        .PRIO_BITS (PRIO_BITS),
        .NUM_GROUPS(NUM_GROUPS),
        .GW        (GW)
    ) u_sel (
        .has_any   (has_any),
        .low_idx   (low_idx),
        .found     (found),
        .best_idx  (best_idx),
        .best_group(best_group)
    );

    apt_bp_unit #(
        .NUM_GROUPS(NUM_GROUPS),
        .GW        (GW),
        .MIN_BP    (MIN_BP)
    ) u_bp (
        .clk      (clk),
        .rst_n    (rst_n),
        .bp_wr    (bp_wr),
        .bp_group (bp_group),
        .bp_val   (bp_val),
        .common_bp(common_bp),
        .prio_mask(prio_mask)
    );

    assign any_active   = found;
    assign owner_group  = best_group;
    assign running_prio = found ? (8'(best_idx) << SHIFT) : 8'hFF;

    // R3: idle reads as the lowest priority
    a_r3_idle_ff: assert property (@(posedge clk) disable iff (!rst_n)
        !any_active |-> running_prio == 8'hFF);

    // R2: after a valid activation the running priority is at least as urgent
    a_r2_act_bound: assert property (@(posedge clk) disable iff (!rst_n)
        act_ok |=> running_prio <= ($past(act_prio) & LEVEL_MASK));

    // R5: a lone drop never makes the running priority more urgent
    a_r5_drop_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_valid && !act_valid) |=> running_prio >= $past(running_prio));

endmodule

// File: tb/sim_apt_tracker.sv
module sim_apt_tracker;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        act_valid = 1'b0;
    logic [7:0]  act_prio = '0;
    logic [1:0]  act_group = '0;
    logic        drop_valid = 1'b0;
    logic [1:0]  drop_group = '0;
    logic        bp_wr = 1'b0;
    logic [1:0]  bp_group = '0;
    logic [2:0]  bp_val = '0;
    logic        common_bp = 1'b0;
    logic [7:0]  running_prio;
    logic        any_active;
    logic [1:0]  owner_group;
    logic [23:0] prio_mask;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    apt_tracker u0 (
        .clk(clk), .rst_n(rst_n),
        .act_valid(act_valid), .act_prio(act_prio), .act_group(act_group),
        .drop_valid(drop_valid), .drop_group(drop_group),
        .bp_wr(bp_wr), .bp_group(bp_group), .bp_val(bp_val),
        .common_bp(common_bp),
        .running_prio(running_prio), .any_active(any_active),
        .owner_group(owner_group), .prio_mask(prio_mask)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not finish (actual=%0d expected<20000)", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_state(input string req, input logic [7:0] rp, input logic aa, input logic [1:0] og);
        chk({req, " running"}, 32'(running_prio), 32'(rp));
        chk({req, " any"}, 32'(any_active), 32'(aa));
        chk({req, " owner"}, 32'(owner_group), 32'(og));
    endtask

    // one edge: strobes set before are seen once, then released
    task automatic step();
        @(posedge clk);
        #2;
        act_valid = 1'b0;
        drop_valid = 1'b0;
        bp_wr = 1'b0;
    endtask

    task automatic activate(input logic [1:0] g, input logic [7:0] p);
        act_valid = 1'b1; act_group = g; act_prio = p;
        step();
    endtask

    task automatic drop(input logic [1:0] g);
        drop_valid = 1'b1; drop_group = g;
        step();
    endtask

    task automatic write_bp(input logic [1:0] g, input logic [2:0] v);
        bp_wr = 1'b1; bp_group = g; bp_val = v;
        step();
    endtask

    task automatic t_reset();
        chk_state("R1", 8'hFF, 1'b0, 2'd0);
        chk("R1 masks", 32'(prio_mask), 32'hFCFCFC);
    endtask

    task automatic t_basic();
        activate(2'd1, 8'h43);
        chk_state("R2 R3 first activation", 8'h40, 1'b1, 2'd1);
        activate(2'd0, 8'h80);
        chk_state("R3 less urgent added", 8'h40, 1'b1, 2'd1);
        drop(2'd0);
        chk_state("R5 drop wrong group ignored", 8'h40, 1'b1, 2'd1);
        drop(2'd1);
        chk_state("R5 drop owner", 8'h80, 1'b1, 2'd0);
        drop(2'd0);
        chk_state("R5 drop last", 8'hFF, 1'b0, 2'd0);
        drop(2'd0);
        chk_state("R5 drop when idle", 8'hFF, 1'b0, 2'd0);
    endtask

    task automatic t_tie();
        activate(2'd2, 8'h20);
        activate(2'd0, 8'h21);
        chk_state("R4 tie lowest group", 8'h20, 1'b1, 2'd0);
        drop(2'd0);
        chk_state("R4 after tie drop", 8'h20, 1'b1, 2'd2);
        drop(2'd2);
        chk_state("R4 empty", 8'hFF, 1'b0, 2'd0);
    endtask

    task automatic t_words();
        activate(2'd1, 8'h80);
        activate(2'd0, 8'h7C);
        chk_state("R10 index 31 beats 32", 8'h7C, 1'b1, 2'd0);
        activate(2'd2, 8'hFC);
        drop(2'd0);
        chk_state("R10 word 1 level", 8'h80, 1'b1, 2'd1);
        drop(2'd1);
        chk_state("R10 top level", 8'hFC, 1'b1, 2'd2);
        drop(2'd2);
        chk_state("R10 empty", 8'hFF, 1'b0, 2'd0);
    endtask

    task automatic t_same_cycle();
        activate(2'd0, 8'h10);
        act_valid = 1'b1; act_group = 2'd1; act_prio = 8'h30;
        drop_valid = 1'b1; drop_group = 2'd0;
        step();
        chk_state("R6 drop and activate together", 8'h30, 1'b1, 2'd1);
        activate(2'd1, 8'h31);
        chk_state("R6 repeated level", 8'h30, 1'b1, 2'd1);
        drop(2'd1);
        chk_state("R6 single mark removed", 8'hFF, 1'b0, 2'd0);
    endtask

    task automatic t_bad_group();
        activate(2'd3, 8'h00);
        chk_state("R7 group out of range", 8'hFF, 1'b0, 2'd0);
    endtask

    task automatic t_bp();
        write_bp(2'd0, 3'd0);
        chk("R8 clamp to floor", 32'(prio_mask[7:0]), 32'hFC);
        write_bp(2'd1, 3'd7);
        write_bp(2'd2, 3'd4);
        chk("R8 masks", 32'(prio_mask), 32'hE000FC);
    endtask

    task automatic t_common();
        common_bp = 1'b1;
        #1;
        chk("R9 follow bp0+1", 32'(prio_mask), 32'hF8F8FC);
        write_bp(2'd0, 3'd6);
        chk("R9 saturate at 7", 32'(prio_mask), 32'h000080);
        common_bp = 1'b0;
        #1;
        chk("R9 own values return", 32'(prio_mask), 32'hE00080);
    endtask

    initial begin
        #(CLK_PERIOD*2 + 2);
        rst_n = 1'b1;
        step();
        t_reset();
        t_basic();
        t_tie();
        t_words();
        t_same_cycle();
        t_bad_group();
        t_bp();
        t_common();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule